// File: doc/BRIEF.md
# Tagged-Token Operand Matcher

This block is the front end of a small tagged-token dataflow engine. Each token that arrives names the instruction that consumes it, says whether it is that instruction's left or right operand, and carries a data word. The unit does not use a program counter. An instruction runs only once the unit has found both of its operands by comparing tags in a small associative waiting table. A token with no partner yet waiting is parked in the table. A token that finds its partner frees that entry and sends the operand pair down the pipeline. Instructions marked single-operand skip the table and run at once.

The pipeline has five steps. A token queue feeds the matching step. Next comes the fetch of the instruction word from a writable program store indexed by tag, then a small arithmetic step, and last a form step that builds one result token per enabled destination. A destination marked external leaves the block on the result outputs. Any other destination goes back into the token queue as a new token. The program store is loaded through a write port. Input tokens use a valid/ready handshake. Result tokens are presented for one cycle each with no back-pressure.

Top module: `tmu_top`

## Requirements
- R1: Reset empties the token queue, the waiting table and the pipeline, and sets every program word to zero (two-operand add with no destinations). After reset `inReady` is 1 and `outValid` is 0.
- R2: A two-operand token fires when the table holds a token with the same tag and the other port. The port-0 token is the left operand and the port-1 token the right operand, whatever order they arrived in. The matched entry is freed when the pair is issued.
- R3: Two tokens with the same tag and the same port do not match each other and are both parked. A later opposite-port token pairs with the lowest-numbered occupied matching entry, which is the first one parked in an otherwise empty table.
- R4: Tokens with different tags never pair, whatever their ports.
- R5: A token whose instruction has the single flag set fires at once, with its data as the left operand and zero as the right. It does not touch the table and still fires when the table is full.
- R6: If the token at the head of the queue needs a table slot, finds no partner, and the table is full, `inReady` is 0 and stays 0 until reset.
- R7: Opcode 0 adds, opcode 1 subtracts (left minus right), opcode 2 multiplies and keeps the low DATA_W bits, and opcode 3 passes the left operand. All results wrap modulo 2^DATA_W.
- R8: The form step emits one token per enabled destination, destination 0 before destination 1. Each token carries the destination's tag and port and the result word. An instruction with no enabled destination emits nothing.
- R9: A destination with the external bit clear is pushed back into the token queue and is then matched like an arriving token, so results can chain into later instructions.
- R10: A program word written through `progWe`/`progAddr`/`progWord` uses this bit layout (17 bits with TAG_W=4): [16:15] opcode, [14] single, then two 7-bit destination fields, destination 0 at [13:7] and destination 1 at [6:0]. Each destination field is {enable, external, tag[3:0], port}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input token is offered |
| inReady | output | 1 | Input token is accepted this cycle when inValid is 1 |
| inTag | input | TAG_W | Consuming instruction tag |
| inPort | input | 1 | Operand side: 0 left, 1 right |
| inData | input | DATA_W | Operand value |
| progWe | input | 1 | Program store write enable |
| progAddr | input | TAG_W | Program store address (instruction tag) |
| progWord | input | INSTR_W | Program word, layout given in R10 |
| outValid | output | 1 | An external result token is presented |
| outTag | output | TAG_W | Destination tag of the result token |
| outPort | output | 1 | Destination port of the result token |
| outData | output | DATA_W | Result value |

## Verification
The hardest states to reach from the ports are a full waiting table and the stall that follows it. The stimulus parks one same-tag, same-port token per slot to fill the table. It then shows that a single-operand token still passes through, and then offers a token with a new tag to freeze the input. Reset is the only way out of that stall. A third hard case is a result that loops back and completes a pair. A two-step chain reaches it: a multiply result feeds an add whose right operand was parked beforehand. The operator behaviour is covered by a sweep over every opcode, several operand pairs and both arrival orders.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  parameter int TAG_W  = 4;
  parameter int DATA_W = 16;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_PASS = 2'd3} op_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              port;
    logic [DATA_W-1:0] data;
  } token_t;

  typedef struct packed {
    logic             en;
    logic             ext;
    logic [TAG_W-1:0] tag;
    logic             port;
  } dest_t;

  typedef struct packed {
    op_e   op;
    logic  single;
    dest_t d0;
    dest_t d1;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // strobes from control to datapath
  typedef struct packed {
    logic qPushIn;
    logic qPushLoop;
    logic qPop;
    logic stAlloc;
    logic stFree;
    logic pairLoad;
    logic execLoad;
    logic formLoad;
    logic emit0;
    logic emit1;
  } tmu_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic headValid;
    logic headSingle;
    logic headHit;
    logic storeFull;
    logic qFull;
    logic pend0;
    logic pend1;
    logic curExt;
  } tmu_status_t;
endpackage

// File: rtl/tmu_datapath.sv
module tmu_datapath
  import tmu_pkg::*;
#(
  parameter int STORE_N = 4,
  parameter int QUEUE_D = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  token_t      inTok,
  input  logic        progWe,
  input  logic [TAG_W-1:0] progAddr,
  input  instr_t      progWord,
  input  tmu_strobe_t stb,
  output tmu_status_t sts,
  output token_t      outTok
);
  localparam int QPW    = (QUEUE_D > 1) ? $clog2(QUEUE_D) : 1;
  localparam int QCW    = $clog2(QUEUE_D + 1);
  localparam int SIW    = (STORE_N > 1) ? $clog2(STORE_N) : 1;
  localparam int PROG_N = 1 << TAG_W;

  // ---------------- program store ----------------
  instr_t progMem [PROG_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PROG_N; i++) progMem[i] <= '0;
    end else if (progWe) begin
      progMem[progAddr] <= progWord;
    end
  end

  // ---------------- token queue ----------------
  token_t         qMem [QUEUE_D];
  logic [QPW-1:0] wrPtr, rdPtr;
  logic [QCW-1:0] qCount;
  token_t         pushTok, loopTok, head;
  logic           qPush;

  function automatic logic [QPW-1:0] nextPtr(input logic [QPW-1:0] p);
    return (p == QPW'(QUEUE_D - 1)) ? '0 : p + 1'b1;
  endfunction

  assign qPush   = stb.qPushIn | stb.qPushLoop;
  assign pushTok = stb.qPushLoop ? loopTok : inTok;
  assign head    = qMem[rdPtr];

  always_ff @(posedge clk) begin
    if (qPush) qMem[wrPtr] <= pushTok;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (qPush)    wrPtr <= nextPtr(wrPtr);
      if (stb.qPop) rdPtr <= nextPtr(rdPtr);
      case ({qPush, stb.qPop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // ---------------- waiting table ----------------
  logic [STORE_N-1:0] stV;
  token_t             stTok [STORE_N];
  logic [STORE_N-1:0] hitVec;
  logic [SIW-1:0]     hitIdx, freeIdx;
  token_t             partner;

  for (genvar g = 0; g < STORE_N; g++) begin : g_cmp
    assign hitVec[g] = stV[g] && (stTok[g].tag == head.tag) && (stTok[g].port != head.port);
  end

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = STORE_N - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx  = SIW'(i);
      if (!stV[i])   freeIdx = SIW'(i);
    end
  end

  assign partner = stTok[hitIdx];

  always_ff @(posedge clk) begin
    if (stb.stAlloc) stTok[freeIdx] <= head;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stV <= '0;
    end else begin
      if (stb.stAlloc) stV[freeIdx] <= 1'b1;
      if (stb.stFree)  stV[hitIdx]  <= 1'b0;
    end
  end

  // ---------------- pair register (match -> fetch) ----------------
  logic [TAG_W-1:0]  pairTag;
  logic [DATA_W-1:0] pairA, pairB;
  logic              headSingle;

  assign headSingle = progMem[head.tag].single;

  always_ff @(posedge clk) begin
    if (stb.pairLoad) begin
      pairTag <= head.tag;
      if (headSingle) begin
        pairA <= head.data;
        pairB <= '0;
      end else if (head.port) begin
        pairA <= partner.data;
        pairB <= head.data;
      end else begin
        pairA <= head.data;
        pairB <= partner.data;
      end
    end
  end

  // ---------------- execute register (fetch -> execute) ----------------
  op_e               execOp;
  dest_t             execD0, execD1;
  logic [DATA_W-1:0] execA, execB, execRes;
  instr_t            fetched;
  logic [2*DATA_W-1:0] prod;

  assign fetched = progMem[pairTag];

  always_ff @(posedge clk) begin
    if (stb.execLoad) begin
      execOp <= fetched.op;
      execD0 <= fetched.d0;
      execD1 <= fetched.d1;
      execA  <= pairA;
      execB  <= pairB;
    end
  end

  assign prod = execA * execB;

  always_comb begin
    case (execOp)
      OP_ADD:  execRes = execA + execB;
      OP_SUB:  execRes = execA - execB;
      OP_MUL:  execRes = prod[DATA_W-1:0];
      default: execRes = execA;
    endcase
  end

  // ---------------- form register ----------------
  logic [DATA_W-1:0] formRes;
  dest_t             formD0, formD1, curDest;

  always_ff @(posedge clk) begin
    if (stb.formLoad) formRes <= execRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      formD0 <= '0;
      formD1 <= '0;
    end else if (stb.formLoad) begin
      formD0 <= execD0;
      formD1 <= execD1;
    end else begin
      if (stb.emit0) formD0.en <= 1'b0;
      if (stb.emit1) formD1.en <= 1'b0;
    end
  end

  assign curDest = formD0.en ? formD0 : formD1;
  assign loopTok = '{tag: curDest.tag, port: curDest.port, data: formRes};
  assign outTok  = loopTok;

  // ---------------- status ----------------
  assign sts.headValid  = (qCount != '0);
  assign sts.headSingle = headSingle;
  assign sts.headHit    = |hitVec;
  assign sts.storeFull  = &stV;
  assign sts.qFull      = (qCount == QCW'(QUEUE_D));
  assign sts.pend0      = formD0.en;
  assign sts.pend1      = formD1.en;
  assign sts.curExt     = curDest.ext;
endmodule

// File: rtl/tmu_control.sv
module tmu_control
  import tmu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  tmu_status_t sts,
  output tmu_strobe_t stb,
  output logic        inReady,
  output logic        outValid
);
  logic pairV, execV;
  logic formBusy, emitOk, emitLast, loopWant;
  logic formReady, execAdv, execReady, pairAdv, pairReady;
  logic needSlot, matchBlock, headFire, headPark;

  // form step: one destination per cycle
  assign formBusy  = sts.pend0 | sts.pend1;
  assign loopWant  = formBusy && !sts.curExt;
  assign emitOk    = formBusy && (sts.curExt || !sts.qFull);
  assign emitLast  = emitOk && (sts.pend0 ^ sts.pend1);
  assign formReady = !formBusy || emitLast;

  // pipeline advance
  assign execAdv   = execV && formReady;
  assign execReady = !execV || formReady;
  assign pairAdv   = pairV && execReady;
  assign pairReady = !pairV || execReady;

  // matching step
  assign needSlot   = !sts.headSingle && !sts.headHit;
  assign matchBlock = sts.headValid && needSlot && sts.storeFull;
  assign headFire   = sts.headValid && !needSlot && pairReady;
  assign headPark   = sts.headValid && needSlot && !sts.storeFull;

  assign inReady  = !sts.qFull && !loopWant && !matchBlock;
  assign outValid = emitOk && sts.curExt;

  always_comb begin
    stb           = '0;
    stb.qPushIn   = inValid && inReady;
    stb.qPushLoop = emitOk && !sts.curExt;
    stb.qPop      = headFire || headPark;
    stb.stAlloc   = headPark;
    stb.stFree    = headFire && !sts.headSingle;
    stb.pairLoad  = headFire;
    stb.execLoad  = pairAdv;
    stb.formLoad  = execAdv;
    stb.emit0     = emitOk && sts.pend0;
    stb.emit1     = emitOk && !sts.pend0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairV <= 1'b0;
      execV <= 1'b0;
    end else begin
      if (headFire)     pairV <= 1'b1;
      else if (pairAdv) pairV <= 1'b0;
      if (pairAdv)      execV <= 1'b1;
      else if (execAdv) execV <= 1'b0;
    end
  end
endmodule

// File: rtl/tmu_top.sv
module tmu_top
  import tmu_pkg::*;
#(
  parameter int STORE_N = 4,
  parameter int QUEUE_D = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [TAG_W-1:0]   inTag,
  input  logic               inPort,
  input  logic [DATA_W-1:0]  inData,
  input  logic               progWe,
  input  logic [TAG_W-1:0]   progAddr,
  input  logic [INSTR_W-1:0] progWord,
  output logic               outValid,
  output logic [TAG_W-1:0]   outTag,
  output logic               outPort,
  output logic [DATA_W-1:0]  outData
);
  tmu_strobe_t stb;
  tmu_status_t sts;
  token_t      inTok, outTok;

  assign inTok = '{tag: inTag, port: inPort, data: inData};

  tmu_datapath #(.STORE_N(STORE_N), .QUEUE_D(QUEUE_D)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inTok    (inTok),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progWord (instr_t'(progWord)),
    .stb      (stb),
    .sts      (sts),
    .outTok   (outTok)
  );

  tmu_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sts      (sts),
    .stb      (stb),
    .inReady  (inReady),
    .outValid (outValid)
  );

  assign outTag  = outTok.tag;
  assign outPort = outTok.port;
  assign outData = outTok.data;
endmodule

// File: rtl/tmu_checker.sv
module tmu_checker
  import tmu_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input tmu_strobe_t stb,
  input tmu_status_t sts
);
  // R1
  out_quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

  // R2
  pair_frees_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stFree |=> !sts.storeFull);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stAlloc |-> !sts.storeFull);

  // R5
  single_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pairLoad && sts.headSingle) |=> $stable(sts.storeFull));

  // R8
  form_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.formLoad |=> ($countones({sts.pend0, sts.pend1}) <= $past($countones({sts.pend0, sts.pend1}))));

  // R9
  one_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.qPushIn, stb.qPushLoop}));
endmodule

bind tmu_top tmu_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .stb      (stb),
  .sts      (sts)
);

// File: tb/tb_tmu_top.sv
`timescale 1ns/1ps
module tb_tmu_top;
  import tmu_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               inReady;
  logic [TAG_W-1:0]   inTag = '0;
  logic               inPort = 1'b0;
  logic [DATA_W-1:0]  inData = '0;
  logic               progWe = 1'b0;
  logic [TAG_W-1:0]   progAddr = '0;
  logic [INSTR_W-1:0] progWord = '0;
  logic               outValid;
  logic [TAG_W-1:0]   outTag;
  logic               outPort;
  logic [DATA_W-1:0]  outData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [TAG_W-1:0]  capTag[$];
  logic              capPort[$];
  logic [DATA_W-1:0] capData[$];

  always #2.5 clk = ~clk;

  tmu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inTag(inTag), .inPort(inPort), .inData(inData),
    .progWe(progWe), .progAddr(progAddr), .progWord(progWord),
    .outValid(outValid), .outTag(outTag), .outPort(outPort), .outData(outData)
  );

  always @(negedge clk) begin
    if (rstN && outValid) begin
      capTag.push_back(outTag);
      capPort.push_back(outPort);
      capData.push_back(outData);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] mkDest(input bit en, input bit ext, input int tag, input bit port);
    return {en, ext, 4'(tag), port};
  endfunction

  // R10 layout: opcode, single, dest0, dest1
  function automatic logic [INSTR_W-1:0] mkWord(input int op, input bit single,
                                                input logic [6:0] d0, input logic [6:0] d1);
    return {2'(op), single, d0, d1};
  endfunction

  function automatic logic [DATA_W-1:0] model(input int op, input logic [DATA_W-1:0] l,
                                             input logic [DATA_W-1:0] r);
    logic [2*DATA_W-1:0] p;
    p = l * r;
    case (op)
      0: return l + r;
      1: return l - r;
      2: return p[DATA_W-1:0];
      default: return l;
    endcase
  endfunction

  task automatic writeProg(input int addr, input logic [INSTR_W-1:0] w);
    @(negedge clk);
    progWe = 1'b1; progAddr = 4'(addr); progWord = w;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic loadProgram();
    writeProg(2,  mkWord(1, 0, mkDest(1, 1, 2, 0),   '0));
    writeProg(3,  mkWord(1, 0, mkDest(1, 1, 12, 0),  '0));
    writeProg(4,  mkWord(1, 0, mkDest(1, 1, 13, 1),  '0));
    writeProg(6,  mkWord(0, 0, mkDest(1, 1, 14, 1),  mkDest(1, 1, 15, 0)));
    writeProg(7,  mkWord(2, 0, mkDest(1, 0, 8, 0),   '0));
    writeProg(8,  mkWord(0, 0, mkDest(1, 1, 9, 0),   '0));
    writeProg(9,  mkWord(0, 1, mkDest(1, 1, 1, 1),   '0));
    writeProg(11, mkWord(0, 0, '0, '0));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; progWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    capTag.delete(); capPort.delete(); capData.delete();
  endtask

  task automatic sendTok(input int tag, input bit port, input logic [DATA_W-1:0] data);
    int tmo = 0;
    @(negedge clk);
    inValid = 1'b1; inTag = 4'(tag); inPort = port; inData = data;
    #1;
    while (!inReady && tmo < 200) begin
      @(negedge clk); #1; tmo++;
    end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic expectOut(input string req, input int tag, input bit port, input logic [DATA_W-1:0] data);
    int w = 0;
    while (capTag.size() == 0 && w < 60) begin
      @(negedge clk); w++;
    end
    if (capTag.size() == 0) begin
      check(1'b0, req, 0, data);
    end else begin
      logic [TAG_W-1:0] t; logic p; logic [DATA_W-1:0] d;
      t = capTag.pop_front(); p = capPort.pop_front(); d = capData.pop_front();
      check(t == 4'(tag) && p == port && d == data, req, {t, p, d}, {4'(tag), port, data});
    end
  endtask

  task automatic expectNone(input string req);
    repeat (12) @(negedge clk);
    check(capTag.size() == 0, req, capTag.size(), 0);
    capTag.delete(); capPort.delete(); capData.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] lv[4] = '{16'd3, 16'd100, 16'd0, 16'h1234};
    logic [DATA_W-1:0] rv[4] = '{16'd5, 16'd7, 16'hFFFF, 16'h0100};

    doReset();
    @(negedge clk);
    // R1: idle after reset
    check(inReady == 1'b1, "R1 inReady", inReady, 1);
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    // R1: cleared program word has no destination
    sendTok(5, 0, 16'd1);
    sendTok(5, 1, 16'd2);
    expectNone("R1 zero program word");

    loadProgram();

    // R2, R7, R10: opcode sweep, both arrival orders
    for (int op = 0; op < 4; op++) begin
      writeProg(1, mkWord(op, 0, mkDest(1, 1, 10, op[0]), '0));
      for (int k = 0; k < 4; k++) begin
        for (int ord = 0; ord < 2; ord++) begin
          if (ord == 0) begin
            sendTok(1, 0, lv[k]); sendTok(1, 1, rv[k]);
          end else begin
            sendTok(1, 1, rv[k]); sendTok(1, 0, lv[k]);
          end
          expectOut("R7 R2 opcode sweep", 10, op[0], model(op, lv[k], rv[k]));
        end
      end
    end

    // R3: same port parks, lowest entry pairs first
    sendTok(2, 0, 16'd10);
    sendTok(2, 0, 16'd20);
    expectNone("R3 same port no match");
    sendTok(2, 1, 16'd1);
    expectOut("R3 first parked", 2, 0, 16'd9);
    sendTok(2, 1, 16'd2);
    expectOut("R3 second parked", 2, 0, 16'd18);

    // R4: different tags stay apart
    sendTok(3, 0, 16'd7);
    sendTok(4, 1, 16'd5);
    expectNone("R4 tag mismatch");
    sendTok(3, 1, 16'd1);
    expectOut("R4 tag3 pair", 12, 0, 16'd6);
    sendTok(4, 0, 16'd9);
    expectOut("R4 tag4 pair", 13, 1, 16'd4);

    // R8: two destinations in order, zero destinations silent
    sendTok(6, 0, 16'd3);
    sendTok(6, 1, 16'd4);
    expectOut("R8 dest0", 14, 1, 16'd7);
    expectOut("R8 dest1", 15, 0, 16'd7);
    sendTok(11, 0, 16'd1);
    sendTok(11, 1, 16'd2);
    expectNone("R8 no destinations");

    // R9: loop back result completes a parked pair
    sendTok(8, 1, 16'd100);
    sendTok(7, 0, 16'd6);
    sendTok(7, 1, 16'd7);
    expectOut("R9 chained result", 9, 0, 16'd142);

    // R5: single operand with empty table
    sendTok(9, 0, 16'd55);
    expectOut("R5 single fires", 1, 1, 16'd55);

    // R5: fill table, single still passes
    for (int i = 0; i < 4; i++) sendTok(2, 0, 16'(i + 1));
    repeat (4) @(negedge clk);
    check(inReady == 1'b1, "R5 ready with full table", inReady, 1);
    sendTok(9, 1, 16'hBEEF);
    expectOut("R5 single with full table", 1, 1, 16'hBEEF);

    // R6: unmatched token at head with full table stalls input
    sendTok(3, 0, 16'd1);
    repeat (4) @(negedge clk);
    check(inReady == 1'b0, "R6 stall", inReady, 0);
    repeat (10) @(negedge clk);
    check(inReady == 1'b0, "R6 stall holds", inReady, 0);

    // R1: reset clears table
    doReset();
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after second reset", inReady, 1);
    loadProgram();
    sendTok(2, 1, 16'd5);
    expectNone("R1 table emptied by reset");
    sendTok(2, 0, 16'd8);
    expectOut("R1 fresh pair after reset", 2, 0, 16'd3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule